// File: doc/BRIEF.md
# Grouped Interrupt Combiner

The combiner gathers a large number of level-sensitive interrupt inputs and reduces them to one output line per group of eight. Input line n belongs to group n/8 and occupies bit n mod 8 of that group. Each group holds an 8-bit pending value, which copies the input levels, and an 8-bit enable mask. The group's output is raised while any pending bit is also enabled.

Software controls the block through 32-bit registers with a word address. Each run of four consecutive words serves four adjacent groups. The first word sets enable bits and the second clears them, one byte per group. The third word returns the raw pending bytes and the fourth returns the pending bytes after masking. Two read-only words after this area give a bitmap of every group output. The raw value of each set or clear write is kept in a shadow file and can be read back from the same word.

An external-mode input makes the block ignore input changes for groups at or above a parameterised limit. While it is set, those groups keep their pending bits unchanged.

Top module: `irq_group_combiner`

## Requirements
- R1: Input line n (0 to 511) drives bit n mod 8 of group n/8. Group g (0 to 63) drives grp_irq_o[g].
- R2: grp_irq_o[g] is a register. It is 1 exactly when the bitwise AND of group g's mask and pending value is nonzero. It takes up a change of input or mask at the first rising clock edge after the change.
- R3: At each clock edge a group's pending byte copies its eight input levels. A low input clears its bit again, so nothing is latched.
- R4: Word 4q+0 is the enable-set word, at byte offset 16q for quad q from 0 to 15. Writing it ORs byte k of the data (bits 8k+7:8k) into the mask of group 4q+k. Other mask bits keep their values.
- R5: Word 4q+1 is the enable-clear word, at byte offset 16q+4. Writing it clears, in the mask of group 4q+k, every bit that is 1 in byte k of the data.
- R6: Reading word 4q+2 returns the pending byte of group 4q+k in bits 8k+7:8k. Reading word 4q+3 returns mask AND pending in the same packing. Read data is combinational on the word address.
- R7: Word 64 (byte 0x100) returns the outputs of groups 0 to 31, with group g in bit g. Word 65 (byte 0x104) returns groups 32 to 63, with group g in bit g-32.
- R8: Reading word 4q+0 or 4q+1 returns the last value written to that word. After reset this is 0x01010101 for byte offsets 0xC0, 0xC4, 0xD0 and 0xD4, and 0 for every other such word.
- R9: A write to word 4q+2, word 4q+3, the status words, or any word at or above 64 changes no mask and no shadow word. It sets wr_err_o high for exactly the one cycle after the write edge. A legal write leaves wr_err_o at 0.
- R10: While ext_mode_i is 1, groups with an index at or above EXT_LIMIT (default 16) keep their pending byte and ignore their inputs. Lower groups keep following their inputs. Once ext_mode_i returns to 0, all groups follow their inputs again.
- R11: After reset all masks, pending bits and outputs are 0 and wr_err_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| ext_mode_i | input | 1 | Ignore inputs of groups at or above EXT_LIMIT |
| irq_i | input | 512 | Level interrupt inputs, line n in bit n |
| wr_en_i | input | 1 | Register write strobe |
| word_addr_i | input | 7 | Register word address (byte offset / 4) |
| wr_data_i | input | 32 | Write data |
| rd_data_o | output | 32 | Combinational read data for word_addr_i |
| wr_err_o | output | 1 | One-cycle pulse after an illegal write |
| grp_irq_o | output | 64 | Per-group interrupt outputs |

## Verification
Pending bits, masks, shadow words, group outputs and the error flag are all due at the first rising edge after the stimulus. Read data is due in the same cycle as the address. The bench changes inputs on a falling edge and samples registered results at the next falling edge, which is half a cycle after the one edge that updates them. It reads registers 1 ns after the address is set. One directed case checks, 1 ns after an input change, that the output has not yet moved, and checks it again one edge later. This pins down the single register stage.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

    localparam int DEF_NUM_GROUPS = 64;
    localparam int DEF_GRP_W      = 8;
    localparam int DEF_EXT_LIMIT  = 16;
    localparam int DEF_PRESET_QA  = 12;
    localparam int DEF_PRESET_QB  = 13;
    localparam logic [31:0] DEF_PRESET_VAL = 32'h0101_0101;

    localparam int GRP_PER_QUAD = 4;
    localparam int GRP_PER_STAT = 32;

    typedef enum logic [1:0] {
        WS_SET = 2'd0,
        WS_CLR = 2'd1,
        WS_RAW = 2'd2,
        WS_MSK = 2'd3
    } wsel_e;

endpackage

// File: rtl/irqc_decode.sv
module irqc_decode #(
    parameter int NUM_GROUPS = irqc_pkg::DEF_NUM_GROUPS,
    localparam int NUM_QUADS  = NUM_GROUPS / irqc_pkg::GRP_PER_QUAD,
    localparam int NUM_STATUS = NUM_GROUPS / irqc_pkg::GRP_PER_STAT,
    localparam int WAW = $clog2(NUM_GROUPS) + 1,
    localparam int QW  = $clog2(NUM_QUADS),
    localparam int SW  = (NUM_STATUS > 1) ? $clog2(NUM_STATUS) : 1
) (
    input  logic [WAW-1:0]      waddr_i,
    input  logic                wr_en_i,
    output logic                is_quad_o,
    output logic                is_status_o,
    output logic [QW-1:0]       quad_o,
    output irqc_pkg::wsel_e     wsel_o,
    output logic [SW-1:0]       sidx_o,
    output logic                wr_ok_o,
    output logic                wr_bad_o
);
    localparam int QUAD_WORDS = NUM_QUADS * 4;
    localparam int STAT_END   = QUAD_WORDS + NUM_STATUS;

    always_comb begin
        is_quad_o   = (waddr_i < WAW'(QUAD_WORDS));
        is_status_o = (waddr_i >= WAW'(QUAD_WORDS)) && (waddr_i < WAW'(STAT_END));
        quad_o      = waddr_i[2 +: QW];
        wsel_o      = irqc_pkg::wsel_e'(waddr_i[1:0]);
        sidx_o      = waddr_i[SW-1:0];
        wr_ok_o     = wr_en_i && is_quad_o &&
                      (wsel_o == irqc_pkg::WS_SET || wsel_o == irqc_pkg::WS_CLR);
        wr_bad_o    = wr_en_i && !wr_ok_o;
    end

endmodule

// File: rtl/irqc_group.sv
module irqc_group #(
    parameter int GW = irqc_pkg::DEF_GRP_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          set_i,
    input  logic          clr_i,
    input  logic [GW-1:0] wbyte_i,
    input  logic          drop_i,
    input  logic [GW-1:0] src_i,
    output logic [GW-1:0] mask_o,
    output logic [GW-1:0] pend_o,
    output logic          out_o
);
    typedef struct packed {
        logic [GW-1:0] mask;
        logic [GW-1:0] pend;
        logic          out;
    } grp_st_t;

    grp_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (set_i) st_d.mask = st_q.mask | wbyte_i;
        if (clr_i) st_d.mask = st_q.mask & ~wbyte_i;
        if (!drop_i) st_d.pend = src_i;
        st_d.out = |(st_d.mask & st_d.pend);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign mask_o = st_q.mask;
    assign pend_o = st_q.pend;
    assign out_o  = st_q.out;

endmodule

// File: rtl/irqc_rdmux.sv
module irqc_rdmux #(
    parameter int NUM_GROUPS = irqc_pkg::DEF_NUM_GROUPS,
    parameter int GW = irqc_pkg::DEF_GRP_W,
    localparam int DW = irqc_pkg::GRP_PER_QUAD * GW,
    localparam int NUM_QUADS  = NUM_GROUPS / irqc_pkg::GRP_PER_QUAD,
    localparam int NUM_STATUS = NUM_GROUPS / irqc_pkg::GRP_PER_STAT,
    localparam int NUM_SHADOW = NUM_QUADS * 2,
    localparam int QW = $clog2(NUM_QUADS),
    localparam int SW = (NUM_STATUS > 1) ? $clog2(NUM_STATUS) : 1
) (
    input  logic                           is_quad_i,
    input  logic                           is_status_i,
    input  logic [QW-1:0]                  quad_i,
    input  irqc_pkg::wsel_e                wsel_i,
    input  logic [SW-1:0]                  sidx_i,
    input  logic [NUM_SHADOW-1:0][DW-1:0]  shadow_i,
    input  logic [NUM_GROUPS*GW-1:0]       mask_i,
    input  logic [NUM_GROUPS*GW-1:0]       pend_i,
    input  logic [NUM_GROUPS-1:0]          out_i,
    output logic [DW-1:0]                  rd_data_o
);
    logic [DW-1:0] raw_w, msk_w;

    always_comb begin
        raw_w = pend_i[quad_i*DW +: DW];
        msk_w = raw_w & mask_i[quad_i*DW +: DW];
        rd_data_o = '0;
        if (is_quad_i) begin
            case (wsel_i)
                irqc_pkg::WS_SET: rd_data_o = shadow_i[{quad_i, 1'b0}];
                irqc_pkg::WS_CLR: rd_data_o = shadow_i[{quad_i, 1'b1}];
                irqc_pkg::WS_RAW: rd_data_o = raw_w;
                default:          rd_data_o = msk_w;
            endcase
        end else if (is_status_i) begin
            rd_data_o = DW'(out_i[sidx_i*irqc_pkg::GRP_PER_STAT +: irqc_pkg::GRP_PER_STAT]);
        end
    end

endmodule

// File: rtl/irq_group_combiner.sv
module irq_group_combiner #(
    parameter int NUM_GROUPS = irqc_pkg::DEF_NUM_GROUPS,
    parameter int GW         = irqc_pkg::DEF_GRP_W,
    parameter int EXT_LIMIT  = irqc_pkg::DEF_EXT_LIMIT,
    parameter int PRESET_QA  = irqc_pkg::DEF_PRESET_QA,
    parameter int PRESET_QB  = irqc_pkg::DEF_PRESET_QB,
    parameter logic [irqc_pkg::GRP_PER_QUAD*GW-1:0] PRESET_VAL = irqc_pkg::DEF_PRESET_VAL,
    localparam int DW  = irqc_pkg::GRP_PER_QUAD * GW,
    localparam int WAW = $clog2(NUM_GROUPS) + 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     ext_mode_i,
    input  logic [NUM_GROUPS*GW-1:0] irq_i,
    input  logic                     wr_en_i,
    input  logic [WAW-1:0]           word_addr_i,
    input  logic [DW-1:0]            wr_data_i,
    output logic [DW-1:0]            rd_data_o,
    output logic                     wr_err_o,
    output logic [NUM_GROUPS-1:0]    grp_irq_o
);
    localparam int NUM_QUADS  = NUM_GROUPS / irqc_pkg::GRP_PER_QUAD;
    localparam int NUM_STATUS = NUM_GROUPS / irqc_pkg::GRP_PER_STAT;
    localparam int NUM_SHADOW = NUM_QUADS * 2;
    localparam int QW = $clog2(NUM_QUADS);
    localparam int SW = (NUM_STATUS > 1) ? $clog2(NUM_STATUS) : 1;

    typedef struct packed {
        logic [NUM_SHADOW-1:0][DW-1:0] shadow;
        logic                          err;
    } top_st_t;

    function automatic top_st_t reset_state();
        top_st_t r;
        r = '0;
        for (int i = 0; i < NUM_SHADOW; i++) begin
            if ((i / 2) == PRESET_QA || (i / 2) == PRESET_QB) r.shadow[i] = PRESET_VAL;
        end
        return r;
    endfunction

    logic                is_quad, is_status, wr_ok, wr_bad;
    logic [QW-1:0]       quad;
    irqc_pkg::wsel_e     wsel;
    logic [SW-1:0]       sidx;

    logic [NUM_GROUPS*GW-1:0] mask_flat, pend_flat;
    logic [NUM_GROUPS-1:0]    out_vec;

    top_st_t st_d, st_q;

    irqc_decode #(.NUM_GROUPS(NUM_GROUPS)) u_dec (
        .waddr_i     (word_addr_i),
        .wr_en_i     (wr_en_i),
        .is_quad_o   (is_quad),
        .is_status_o (is_status),
        .quad_o      (quad),
        .wsel_o      (wsel),
        .sidx_o      (sidx),
        .wr_ok_o     (wr_ok),
        .wr_bad_o    (wr_bad)
    );

    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
        localparam bit DROPPABLE = (g >= EXT_LIMIT);
        localparam int LANE = g % irqc_pkg::GRP_PER_QUAD;
        logic in_quad;
        assign in_quad = wr_ok && (quad == QW'(g / irqc_pkg::GRP_PER_QUAD));

        irqc_group #(.GW(GW)) u_grp (
            .clk     (clk),
            .rst_n   (rst_n),
            .set_i   (in_quad && wsel == irqc_pkg::WS_SET),
            .clr_i   (in_quad && wsel == irqc_pkg::WS_CLR),
            .wbyte_i (wr_data_i[LANE*GW +: GW]),
            .drop_i  (ext_mode_i && DROPPABLE),
            .src_i   (irq_i[g*GW +: GW]),
            .mask_o  (mask_flat[g*GW +: GW]),
            .pend_o  (pend_flat[g*GW +: GW]),
            .out_o   (out_vec[g])
        );
    end

    always_comb begin
        st_d = st_q;
        st_d.err = wr_bad;
        if (wr_ok) st_d.shadow[{quad, wsel[0]}] = wr_data_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= reset_state();
        else        st_q <= st_d;
    end

    irqc_rdmux #(.NUM_GROUPS(NUM_GROUPS), .GW(GW)) u_rd (
        .is_quad_i   (is_quad),
        .is_status_i (is_status),
        .quad_i      (quad),
        .wsel_i      (wsel),
        .sidx_i      (sidx),
        .shadow_i    (st_q.shadow),
        .mask_i      (mask_flat),
        .pend_i      (pend_flat),
        .out_i       (out_vec),
        .rd_data_o   (rd_data_o)
    );

    assign wr_err_o  = st_q.err;
    assign grp_irq_o = out_vec;

endmodule

// File: rtl/irqc_checker.sv
module irqc_checker #(
    parameter int NUM_GROUPS = irqc_pkg::DEF_NUM_GROUPS,
    parameter int GW         = irqc_pkg::DEF_GRP_W,
    parameter int EXT_LIMIT  = irqc_pkg::DEF_EXT_LIMIT
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     ext_mode_i,
    input logic [NUM_GROUPS*GW-1:0] irq_i,
    input logic                     wr_en_i,
    input logic                     wr_err_o,
    input logic [NUM_GROUPS-1:0]    grp_irq_o,
    input logic [NUM_GROUPS*GW-1:0] mask_flat,
    input logic [NUM_GROUPS*GW-1:0] pend_flat
);
    localparam int LO_W = EXT_LIMIT * GW;

    logic [NUM_GROUPS-1:0] active;

    always_comb begin
        for (int g = 0; g < NUM_GROUPS; g++)
            active[g] = |(mask_flat[g*GW +: GW] & pend_flat[g*GW +: GW]);
    end

    // R2: registered outputs agree with the stored mask and pending state
    a_r2_out_matches: assert property (@(posedge clk) disable iff (!rst_n)
        grp_irq_o == active);

    // R3: groups below the limit always copy their inputs one edge later
    a_r3_low_follow: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> pend_flat[LO_W-1:0] == $past(irq_i[LO_W-1:0]));

    // R3: outside external mode every group copies its inputs
    a_r3_all_follow: assert property (@(posedge clk) disable iff (!rst_n)
        !ext_mode_i |=> pend_flat == $past(irq_i));

    // R10: in external mode the high groups hold their pending bits
    a_r10_hold_high: assert property (@(posedge clk) disable iff (!rst_n)
        ext_mode_i |=> pend_flat[NUM_GROUPS*GW-1:LO_W] == $past(pend_flat[NUM_GROUPS*GW-1:LO_W]));

    // R9: an error pulse follows a write and comes with no mask change
    a_r9_err_after_wr: assert property (@(posedge clk) disable iff (!rst_n)
        wr_err_o |-> $past(wr_en_i));

    a_r9_no_mask_change: assert property (@(posedge clk) disable iff (!rst_n)
        wr_err_o |-> $stable(mask_flat));

endmodule

bind irq_group_combiner irqc_checker #(
    .NUM_GROUPS (NUM_GROUPS),
    .GW         (GW),
    .EXT_LIMIT  (EXT_LIMIT)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ext_mode_i (ext_mode_i),
    .irq_i      (irq_i),
    .wr_en_i    (wr_en_i),
    .wr_err_o   (wr_err_o),
    .grp_irq_o  (grp_irq_o),
    .mask_flat  (mask_flat),
    .pend_flat  (pend_flat)
);

// File: tb/irq_group_combiner_test.sv
`timescale 1ns/1ps
module irq_group_combiner_test;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         ext_mode = 1'b0;
    logic [511:0] irq = '0;
    logic         wr_en = 1'b0;
    logic [6:0]   waddr = '0;
    logic [31:0]  wdata = '0;
    logic [31:0]  rdata;
    logic         werr;
    logic [63:0]  gout;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    irq_group_combiner uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .ext_mode_i  (ext_mode),
        .irq_i       (irq),
        .wr_en_i     (wr_en),
        .word_addr_i (waddr),
        .wr_data_i   (wdata),
        .rd_data_o   (rdata),
        .wr_err_o    (werr),
        .grp_irq_o   (gout)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic rd_chk(input string tag, input logic [8:0] byte_off, input logic [31:0] exp);
        @(negedge clk);
        waddr = byte_off[8:2];
        #1;
        check(tag, 64'(rdata), 64'(exp));
    endtask

    task automatic wr(input string tag, input logic [8:0] byte_off, input logic [31:0] d,
                      input logic exp_err);
        @(negedge clk);
        waddr = byte_off[8:2];
        wdata = d;
        wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
        check(tag, 64'(werr), 64'(exp_err));
    endtask

    task automatic drive(input int n, input logic v);
        @(negedge clk);
        irq[n] = v;
        @(negedge clk);
    endtask

    task automatic t_reset();
        check("R11 outputs zero", gout, 64'h0);
        check("R11 err zero", 64'(werr), 64'h0);
        rd_chk("R8 shadow 0x000 reset", 9'h000, 32'h0);
        rd_chk("R8 shadow 0xC0 reset", 9'h0C0, 32'h0101_0101);
        rd_chk("R8 shadow 0xC4 reset", 9'h0C4, 32'h0101_0101);
        rd_chk("R8 shadow 0xD0 reset", 9'h0D0, 32'h0101_0101);
        rd_chk("R8 shadow 0xD4 reset", 9'h0D4, 32'h0101_0101);
        rd_chk("R8 shadow 0xE0 reset", 9'h0E0, 32'h0);
        rd_chk("R11 masked quad12 zero", 9'h0CC, 32'h0);
        rd_chk("R7 status lo reset", 9'h100, 32'h0);
        rd_chk("R7 status hi reset", 9'h104, 32'h0);
    endtask

    task automatic t_pending();
        drive(19, 1'b1);
        rd_chk("R1 R3 line 19 in group 2 bit 3", 9'h008, 32'h0008_0000);
        check("R2 unmasked stays low", gout, 64'h0);
        drive(511, 1'b1);
        rd_chk("R1 line 511 in group 63 bit 7", 9'h0F8, 32'h8000_0000);
        drive(511, 1'b0);
        rd_chk("R3 low input clears pending", 9'h0F8, 32'h0);
    endtask

    task automatic t_enable();
        wr("R9 legal set no err", 9'h000, 32'h0008_0000, 1'b0);
        check("R4 R2 group 2 out high", gout, 64'h4);
        rd_chk("R6 masked word", 9'h00C, 32'h0008_0000);
        drive(18, 1'b1);
        rd_chk("R6 raw word two bits", 9'h008, 32'h000C_0000);
        rd_chk("R6 masked word filters", 9'h00C, 32'h0008_0000);
        wr("R4 set group 40 bit0", 9'h0A0, 32'h0000_0001, 1'b0);
        @(negedge clk);
        irq[320] = 1'b1;
        #1;
        check("R2 output not yet updated", 64'(gout[40]), 64'h0);
        @(negedge clk);
        check("R2 output one edge later", 64'(gout[40]), 64'h1);
        rd_chk("R7 status hi group 40", 9'h104, 32'h0000_0100);
        rd_chk("R7 status lo group 2", 9'h100, 32'h0000_0004);
    endtask

    task automatic t_clear();
        wr("R5 clear group 2", 9'h004, 32'h0008_0000, 1'b0);
        check("R5 group 2 out low", gout, 64'h0000_0100_0000_0000);
        rd_chk("R5 masked cleared", 9'h00C, 32'h0);
        rd_chk("R5 raw unaffected", 9'h008, 32'h000C_0000);
        rd_chk("R7 status lo cleared", 9'h100, 32'h0);
        wr("R4 set bit1 group 40", 9'h0A0, 32'h0000_0002, 1'b0);
        drive(321, 1'b1);
        rd_chk("R4 set ORs into mask", 9'h0AC, 32'h0000_0003);
        wr("R5 clear bit0 group 40", 9'h0A4, 32'h0000_0001, 1'b0);
        rd_chk("R5 clear only named bit", 9'h0AC, 32'h0000_0002);
        drive(321, 1'b0);
        check("R2 out low with disjoint bits", 64'(gout[40]), 64'h0);
        wr("R4 re-enable bit0 group 40", 9'h0A0, 32'h0000_0001, 1'b0);
        check("R2 out high again", 64'(gout[40]), 64'h1);
    endtask

    task automatic t_shadow();
        rd_chk("R8 shadow set word quad10", 9'h0A0, 32'h0000_0001);
        rd_chk("R8 shadow clear word quad10", 9'h0A4, 32'h0000_0001);
        rd_chk("R8 shadow set word quad0", 9'h000, 32'h0008_0000);
        rd_chk("R8 shadow clear word quad0", 9'h004, 32'h0008_0000);
    endtask

    task automatic t_illegal();
        wr("R9 status write err", 9'h100, 32'hFFFF_FFFF, 1'b1);
        @(negedge clk);
        check("R9 err one cycle only", 64'(werr), 64'h0);
        rd_chk("R9 status hi unchanged", 9'h104, 32'h0000_0100);
        rd_chk("R9 status lo unchanged", 9'h100, 32'h0);
        wr("R9 raw word write err", 9'h0A8, 32'h0000_00FF, 1'b1);
        rd_chk("R9 mask unchanged", 9'h0AC, 32'h0000_0001);
        wr("R9 masked word write err", 9'h0CC, 32'hFFFF_FFFF, 1'b1);
        rd_chk("R9 quad12 mask unchanged", 9'h0CC, 32'h0);
        wr("R9 out of window err", 9'h1F0, 32'hFFFF_FFFF, 1'b1);
        rd_chk("R9 shadow unchanged", 9'h0A0, 32'h0000_0001);
        check("R9 outputs unchanged", gout, 64'h0000_0100_0000_0000);
    endtask

    task automatic t_ext();
        @(negedge clk);
        ext_mode = 1'b1;
        irq[320] = 1'b0;
        @(negedge clk);
        rd_chk("R10 high group holds pending", 9'h0A8, 32'h0000_0001);
        check("R10 high group out holds", 64'(gout[40]), 64'h1);
        drive(19, 1'b0);
        rd_chk("R10 low group still follows", 9'h008, 32'h0004_0000);
        @(negedge clk);
        ext_mode = 1'b0;
        @(negedge clk);
        rd_chk("R10 follows again after exit", 9'h0A8, 32'h0);
        check("R10 out drops after exit", 64'(gout[40]), 64'h0);
    endtask

    initial begin
        #2_000_000;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_pending();
        t_enable();
        t_clear();
        t_shadow();
        t_illegal();
        t_ext();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule